// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. Each operation presents two operands, a five-bit condition mask and a width select. The block evaluates five relations between the operands: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. A trap is requested when at least one relation selected by the mask is true.

In word mode only the low 32 bits of each operand take part. They are treated as a 32-bit signed value or a 32-bit unsigned value, as each relation requires. In doubleword mode all 64 bits are compared.

The decision is registered. A trap request appears as a one-cycle pulse in the cycle after the valid strobe. Together with the pulse, the block drives the program-exception subtype code that marks the exception as a trap. The pipeline uses this pulse and code to begin exception entry. Instruction decode and exception entry sit outside this block.

Top module: `cond_trap_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `trap_req` is 0 and `trap_code` is 0 after that edge, whatever the other inputs are.
- R2: Mask bit 4 (value 0x10) selects the signed less-than relation, operand A < operand B.
- R3: Mask bit 3 (value 0x08) selects the signed greater-than relation, operand A > operand B.
- R4: Mask bit 2 (value 0x04) selects equality of the compared operand bits.
- R5: Mask bit 1 (value 0x02) selects the unsigned less-than relation, operand A < operand B.
- R6: Mask bit 0 (value 0x01) selects the unsigned greater-than relation, operand A > operand B.
- R7: When several mask bits are set, a trap is raised if any one of the selected relations is true.
- R8: With `wide_mode` = 0, only bits 31:0 are compared, as 32-bit signed or unsigned values. Bits 63:32 have no effect.
- R9: With `wide_mode` = 1, all 64 bits are compared, as 64-bit signed or unsigned values.
- R10: `trap_req` is high for exactly the one cycle after a cycle in which `in_valid` was high and the decision was to trap. A cycle with `in_valid` low never produces a trap request.
- R11: `trap_code` equals the trap subtype value 4'h4 in every cycle where `trap_req` is 1, and is 0 in every other cycle.
- R12: A mask of 0 never traps. A mask of 5'h1F always traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe; operands, mask and mode are sampled when high |
| op_a | input | 64 | First operand (left-hand side of each relation) |
| op_b | input | 64 | Second operand (right-hand side of each relation) |
| cond_mask | input | 5 | Relation select: bit4 signed lt, bit3 signed gt, bit2 eq, bit1 unsigned lt, bit0 unsigned gt |
| wide_mode | input | 1 | 1 = compare 64 bits, 0 = compare low 32 bits |
| trap_req | output | 1 | Registered one-cycle trap request |
| trap_code | output | 4 | Program-exception subtype; the trap value while `trap_req` is high, else 0 |

## Verification
The assertions assume that `in_valid`, the operands, the mask and the mode are known, non-X values at every rising edge once reset is released. They also assume that the comparator inputs are only meaningful in cycles where `in_valid` is high. The bench meets these assumptions by driving every input on the falling edge from reset onward and by holding the operands at defined values even while the strobe is low. Under these conditions each signed pair and each unsigned pair resolves to exactly one of less-than, greater-than or equal. The bench uses operands whose signed and unsigned orderings disagree and operands whose high half would change the result, so the width select and the signedness are exercised separately.

// File: rtl/trap_pkg.sv
// Package: shared parameters and relation bit positions for the conditional
// trap comparator. The relation positions are fixed because the condition mask
// coming from instruction decode uses the same bit order.
package trap_pkg;

    localparam int unsigned DATA_W   = 64;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned REL_N    = 5;
    localparam int unsigned CODE_W   = 4;

    // Bit index of each relation inside the condition mask and hit vector.
    localparam int unsigned REL_UGT  = 0;
    localparam int unsigned REL_ULT  = 1;
    localparam int unsigned REL_EQ   = 2;
    localparam int unsigned REL_SGT  = 3;
    localparam int unsigned REL_SLT  = 4;

    // Program-exception subtype reported for a taken trap.
    localparam logic [CODE_W-1:0] TRAP_SUBTYPE = 4'h4;

    typedef logic [REL_N-1:0] rel_vec_t;

endpackage

// File: rtl/trap_operand_prep.sv
// Module: trap_operand_prep
// Widens both operands by one bit into a common compare space. Signed copies
// are sign-extended and unsigned copies are zero-extended, either from the
// word boundary or from the full data width, depending on the mode.
// Assumes: WORD_W < DATA_W. Purely combinational.
module trap_operand_prep #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned WORD_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              wide,
    output logic [DATA_W:0]   a_sx,
    output logic [DATA_W:0]   b_sx,
    output logic [DATA_W:0]   a_zx,
    output logic [DATA_W:0]   b_zx
);
    localparam int unsigned EXT_W = DATA_W + 1 - WORD_W;

    // Select the extension for each operand copy according to the width mode.
    always_comb begin
        if (wide) begin
            a_sx = {a_in[DATA_W-1], a_in};
            b_sx = {b_in[DATA_W-1], b_in};
            a_zx = {1'b0, a_in};
            b_zx = {1'b0, b_in};
        end else begin
            a_sx = {{EXT_W{a_in[WORD_W-1]}}, a_in[WORD_W-1:0]};
            b_sx = {{EXT_W{b_in[WORD_W-1]}}, b_in[WORD_W-1:0]};
            a_zx = {{EXT_W{1'b0}}, a_in[WORD_W-1:0]};
            b_zx = {{EXT_W{1'b0}}, b_in[WORD_W-1:0]};
        end
    end

endmodule

// File: rtl/trap_relation_eval.sv
// Module: trap_relation_eval
// Evaluates the five operand relations on the prepared operands and places
// each one at its fixed bit position in the hit vector.
// Assumes: the operands are already extended into a common (DATA_W+1)-bit
// space. The clock and reset are used only by the checks.
module trap_relation_eval
    import trap_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chk_en,
    input  logic [DATA_W:0] a_sx,
    input  logic [DATA_W:0] b_sx,
    input  logic [DATA_W:0] a_zx,
    input  logic [DATA_W:0] b_zx,
    output rel_vec_t        rel_hit
);
    logic s_lt, s_gt, u_lt, u_gt, same;

    // Signed ordering of the sign-extended copies.
    always_comb begin
        s_lt = $signed(a_sx) < $signed(b_sx);
        s_gt = $signed(a_sx) > $signed(b_sx);
    end

    // Unsigned ordering and equality of the zero-extended copies.
    always_comb begin
        u_lt = a_zx < b_zx;
        u_gt = a_zx > b_zx;
        same = a_zx == b_zx;
    end

    // Place each relation at its mask bit position.
    always_comb begin
        rel_hit          = '0;
        rel_hit[REL_SLT] = s_lt;
        rel_hit[REL_SGT] = s_gt;
        rel_hit[REL_EQ]  = same;
        rel_hit[REL_ULT] = u_lt;
        rel_hit[REL_UGT] = u_gt;
    end

    // R2 R3 R4: exactly one signed outcome holds for any operand pair
    signed_trichotomy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> $countones({rel_hit[REL_SLT], rel_hit[REL_SGT], rel_hit[REL_EQ]}) == 1);

    // R4 R5 R6: exactly one unsigned outcome holds for any operand pair
    unsigned_trichotomy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> $countones({rel_hit[REL_ULT], rel_hit[REL_UGT], rel_hit[REL_EQ]}) == 1);

endmodule

// File: rtl/trap_decide.sv
// Module: trap_decide
// Gates the relation hits with the condition mask and the valid strobe, then
// registers the trap request and the subtype code.
// Assumes: rel_hit is valid in the same cycle as in_valid. Uses a
// synchronous active-low reset.
module trap_decide
    import trap_pkg::*;
#(
    parameter int unsigned        CODE_W  = 4,
    parameter logic [CODE_W-1:0]  SUBTYPE = 4'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  rel_vec_t          mask,
    input  rel_vec_t          rel_hit,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code
);
    rel_vec_t sel_hit;
    logic     fire;

    // Keep only the relations the mask asks for, under the valid strobe.
    always_comb begin
        sel_hit = mask & rel_hit;
        fire    = in_valid && (|sel_hit);
    end

    // Register the request and its subtype code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_req  <= 1'b0;
            trap_code <= '0;
        end else begin
            trap_req  <= fire;
            trap_code <= fire ? SUBTYPE : '0;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!trap_req && trap_code == '0));

    // R10
    req_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(in_valid));

    // R11
    code_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_code == SUBTYPE);

    // R11
    code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> trap_code == '0);

    // R12
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask == '0) |=> !trap_req);

    // R12
    full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&mask)) |=> trap_req);

endmodule

// File: rtl/cond_trap_unit.sv
// Module: cond_trap_unit (top)
// Conditional trap comparator. It prepares the operands for the selected
// width, evaluates the five relations and raises a registered trap request
// with the trap subtype code when any relation chosen by the mask holds.
// Assumes: all inputs are sampled at the rising edge while in_valid is high.
module cond_trap_unit
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [REL_N-1:0]  cond_mask,
    input  logic              wide_mode,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code
);
    logic [DATA_W:0] a_sx, b_sx, a_zx, b_zx;
    rel_vec_t        rel_hit;

    trap_operand_prep #(
        .DATA_W (DATA_W),
        .WORD_W (WORD_W)
    ) u_prep (
        .a_in (op_a),
        .b_in (op_b),
        .wide (wide_mode),
        .a_sx (a_sx),
        .b_sx (b_sx),
        .a_zx (a_zx),
        .b_zx (b_zx)
    );

    trap_relation_eval #(
        .DATA_W (DATA_W)
    ) u_rel (
        .clk     (clk),
        .rst_n   (rst_n),
        .chk_en  (in_valid),
        .a_sx    (a_sx),
        .b_sx    (b_sx),
        .a_zx    (a_zx),
        .b_zx    (b_zx),
        .rel_hit (rel_hit)
    );

    trap_decide #(
        .CODE_W  (CODE_W),
        .SUBTYPE (TRAP_SUBTYPE)
    ) u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mask      (cond_mask),
        .rel_hit   (rel_hit),
        .trap_req  (trap_req),
        .trap_code (trap_code)
    );

endmodule

// File: tb/cond_trap_unit_tb.sv
module cond_trap_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [4:0]  cond_mask = '0;
    logic        wide_mode = 1'b0;
    logic        trap_req;
    logic [3:0]  trap_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    cond_trap_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .cond_mask (cond_mask),
        .wide_mode (wide_mode),
        .trap_req  (trap_req),
        .trap_code (trap_code)
    );

    // Vector layout: [134] wide, [133:129] mask, [128:65] a, [64:1] b, [0] expected trap
    localparam int NV = 18;
    localparam logic [134:0] VEC [NV] = '{
        {1'b1, 5'b10000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1},                    // R2 -1 < 1 signed
        {1'b1, 5'b00010, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0},                    // R5 max not < 1 unsigned
        {1'b1, 5'b00001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1},                    // R6 max > 1 unsigned
        {1'b1, 5'b01000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0},                    // R3 -1 not > 1 signed
        {1'b1, 5'b01000, 64'h9, 64'h5, 1'b1},                                      // R3 9 > 5
        {1'b1, 5'b00100, 64'h1234, 64'h1234, 1'b1},                                // R4 equal
        {1'b1, 5'b00100, 64'h0000_0001_0000_0005, 64'h5, 1'b0},                    // R9 high half differs
        {1'b0, 5'b00100, 64'h0000_0001_0000_0005, 64'h5, 1'b1},                    // R8 high half ignored
        {1'b0, 5'b10000, 64'h0000_0000_8000_0000, 64'h0, 1'b1},                    // R8 word sign bit
        {1'b1, 5'b10000, 64'h0000_0000_8000_0000, 64'h0, 1'b0},                    // R9 positive in 64 bits
        {1'b0, 5'b00001, 64'h0000_0000_8000_0000, 64'h0, 1'b1},                    // R8 word unsigned gt
        {1'b0, 5'b01000, 64'hFFFF_FFFF_0000_0002, 64'h1, 1'b1},                    // R8 2 > 1 in word
        {1'b1, 5'b01000, 64'hFFFF_FFFF_0000_0002, 64'h1, 1'b0},                    // R9 negative in 64 bits
        {1'b1, 5'b00000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0},                    // R12 zero mask
        {1'b1, 5'b11111, 64'h7, 64'h7, 1'b1},                                      // R12 full mask
        {1'b1, 5'b01010, 64'h5, 64'h9, 1'b1},                                      // R7 ult hit among two
        {1'b1, 5'b10010, 64'h9, 64'h5, 1'b0},                                      // R7 neither selected holds
        {1'b0, 5'b10001, 64'h5, 64'h9, 1'b1}                                       // R7 slt hit among two
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic [4:0] m,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid  = v;
        wide_mode = w;
        cond_mask = m;
        op_a      = a;
        op_b      = b;
    endtask

    initial begin
        // R1: reset with a would-be trap on the inputs
        drive(1'b1, 1'b1, 5'b11111, 64'h3, 64'h3);
        drive(1'b1, 1'b1, 5'b11111, 64'h3, 64'h3);
        check("R1 req", {3'b0, trap_req}, 4'h0);
        check("R1 code", trap_code, 4'h0);
        drive(1'b0, 1'b0, 5'b0, 64'h0, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [134:0] v;
            v = VEC[i];
            drive(1'b1, v[134], v[133:129], v[128:65], v[64:1]);
            drive(1'b0, v[134], v[133:129], v[128:65], v[64:1]);
            if (trap_req !== v[0]) begin
                n_chk++; n_fail++;
                $display("FAIL vector %0d R7 trap rule actual=%b expected=%b", i, trap_req, v[0]);
            end else n_chk++;
            // R11
            check("R11 code", trap_code, v[0] ? 4'h4 : 4'h0);
        end

        // R10: valid low with a full mask produces nothing
        drive(1'b0, 1'b1, 5'b11111, 64'h1, 64'h1);
        drive(1'b0, 1'b1, 5'b11111, 64'h1, 64'h1);
        check("R10 no valid", {3'b0, trap_req}, 4'h0);

        // R10: pulse lasts exactly one cycle
        drive(1'b1, 1'b1, 5'b00100, 64'h8, 64'h8);
        drive(1'b0, 1'b1, 5'b00100, 64'h8, 64'h8);
        check("R10 pulse high", {3'b0, trap_req}, 4'h1);
        drive(1'b0, 1'b1, 5'b00100, 64'h8, 64'h8);
        check("R10 pulse low", {3'b0, trap_req}, 4'h0);
        check("R11 code after pulse", trap_code, 4'h0);

        // R1: reset mid-stream clears the pending request
        drive(1'b1, 1'b1, 5'b11111, 64'h8, 64'h8);
        rst_n = 1'b0;
        drive(1'b0, 1'b1, 5'b11111, 64'h8, 64'h8);
        check("R1 mid reset", {3'b0, trap_req}, 4'h0);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 5'b0, 64'h0, 64'h0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule